// File: doc/BRIEF.md
# Streaming polynomial synthetic divider

This block divides a polynomial by a binomial `(x - alpha)` while its coefficients stream through it. Coefficients enter highest degree first, one per accepted beat on a valid/ready input channel. The block gives one output beat for every input beat. Each output is the next term of the nested-multiplication recurrence. The first `n` outputs of a degree-`n` polynomial are therefore the quotient coefficients, highest degree first. The final output is the remainder, which is also the polynomial evaluated at `alpha`.

The scalar `alpha` is presented on its own input. It is sampled on the beat that carries a polynomial's leading coefficient. It then stays fixed for every later beat of that polynomial, up to and including the beat flagged last. All values are signed fixed-point numbers with `FRAC` fractional bits. A single multiply-accumulate computes each term from the term before it, so the terms form a strict chain. A degree-`n` input costs `n` multiplies and `n` additions.

The output is a single register stage. A stalled output holds both its data and the running term, and it blocks further input until the output is taken.

Top module: `horner_div`

## Requirements
- R1: The output beat for the leading coefficient of a polynomial carries that coefficient unchanged.
- R2: Every later output beat equals the incoming coefficient plus the previous output times the captured alpha. The product is shifted right arithmetically by `FRAC` bits, which truncates toward minus infinity, before the addition. Output beats appear in input order, one per accepted input beat.
- R3: When the sum in R2 lies outside the signed `DW`-bit range, the output clamps to the largest positive value (0x7FFF for the default width) or the most negative value (0x8000).
- R4: `alpha_in` is sampled only on the leading beat of a polynomial. Its value on later beats of the same polynomial, up to the beat flagged last, has no effect on the outputs.
- R5: `out_last` is high on the output beat produced from the input beat flagged with `coef_last`, which is the remainder. It is low on all quotient beats.
- R6: A polynomial of degree zero (a single beat with `coef_last` high) gives exactly one output beat: the coefficient itself, with `out_last` high. The beat after it starts a new polynomial.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold, `coef_ready` is low, and no accepted coefficient is lost.
- R8: After reset, `out_valid` is low, `coef_ready` is high, and the next accepted beat is treated as a leading coefficient, even if reset arrived in the middle of a polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_valid | input | 1 | Input coefficient is present |
| coef_ready | output | 1 | Block can accept a coefficient |
| coef_data | input | DW | Signed fixed-point coefficient |
| coef_last | input | 1 | Marks the constant term (final coefficient) |
| alpha_in | input | DW | Signed fixed-point divisor root, sampled on a leading beat |
| out_valid | output | 1 | Output term is present |
| out_ready | input | 1 | Consumer takes the output term |
| out_data | output | DW | Quotient coefficient or remainder |
| out_last | output | 1 | High when `out_data` is the remainder |

## Verification
On every cycle, the assertions check the handshake rules:
- a stalled output holds and blocks input;
- a leading coefficient passes through unchanged;
- the last flag follows the input flag;
- the captured alpha stays fixed inside a polynomial.

The arithmetic itself is shown only by the bench scenarios, which compare each output against a computed reference. These cover the truncating multiply, saturation in both directions, degree-zero polynomials, alpha changing in the middle of a polynomial, and a reset in the middle of a polynomial.

// File: rtl/horner_div.sv
module horner_div #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_valid,
  output logic          coef_ready,
  input  logic [DW-1:0] coef_data,
  input  logic          coef_last,
  input  logic [DW-1:0] alpha_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int PW = 2 * DW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic          busy;
  logic [DW-1:0] alpha_q;
  logic [DW-1:0] term_q;
  logic          last_q;
  logic          vld_q;

  logic                 fire;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [SW-1:0] sum;
  logic [DW-1:0]        chained;
  logic [DW-1:0]        next_term;

  assign coef_ready = !vld_q || out_ready;
  assign fire       = coef_valid && coef_ready;

  assign prod   = $signed(alpha_q) * $signed(term_q);
  assign scaled = prod >>> FRAC;
  assign sum    = $signed({{(SW-DW){coef_data[DW-1]}}, coef_data})
                + $signed({scaled[PW-1], scaled});

  always_comb begin
    if (sum > MAXV)      chained = MAXV[DW-1:0];
    else if (sum < MINV) chained = MINV[DW-1:0];
    else                 chained = sum[DW-1:0];
  end

  assign next_term = busy ? chained : coef_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      alpha_q <= '0;
      term_q  <= '0;
      last_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (fire) begin
        term_q <= next_term;
        last_q <= coef_last;
        busy   <= !coef_last;
        if (!busy) alpha_q <= alpha_in;
      end
      if (fire)           vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = term_q;
  assign out_last  = last_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !coef_ready);

  assert_lead_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready && !busy) |=> (out_valid && out_data == $past(coef_data)));

  assert_last_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready) |=> (out_last == $past(coef_last)));

  assert_alpha_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(alpha_q));

  assert_deg0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready && coef_last) |=> !busy);
endmodule

// File: tb/horner_div_tb.sv
module horner_div_tb_top;
  localparam int DW = 16;
  localparam int FRAC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_valid = 1'b0, coef_last = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] coef_data = '0, alpha_in = '0;
  logic coef_ready, out_valid, out_last;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  horner_div #(.DW(DW), .FRAC(FRAC)) dut_i (
    .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_ready(coef_ready),
    .coef_data(coef_data), .coef_last(coef_last), .alpha_in(alpha_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] exp_d[$];
  bit            exp_l[$];
  string         exp_t[$];
  bit            m_busy = 0;
  logic [DW-1:0] m_alpha = '0, m_prev = '0;
  bit            accepted;

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(logic [DW-1:0] a, logic [DW-1:0] p,
                                          logic [DW-1:0] c, output bit clamped);
    longint pr, s;
    longint mx = (longint'(1) <<< (DW-1)) - 1;
    longint mn = -(longint'(1) <<< (DW-1));
    pr = longint'($signed(a)) * longint'($signed(p));
    pr = pr >>> FRAC;
    s = longint'($signed(c)) + pr;
    clamped = 1;
    if (s > mx) return mx[DW-1:0];
    if (s < mn) return mn[DW-1:0];
    clamped = 0;
    return s[DW-1:0];
  endfunction

  task automatic cycle(bit mr, bit sv, logic [DW-1:0] c, bit l, logic [DW-1:0] a);
    bit cl;
    logic [DW-1:0] e;
    @(negedge clk);
    out_ready = mr; coef_valid = sv; coef_data = c; coef_last = l; alpha_in = a;
    #1;
    if (out_valid && out_ready) begin
      if (exp_d.size() == 0) check("R2 unexpected output", 1, 0);
      else begin
        string t = exp_t.pop_front();
        check(t, out_data, exp_d.pop_front());
        check("R5 last flag", out_last, exp_l.pop_front());
      end
    end
    accepted = coef_valid && coef_ready;
    if (accepted) begin
      if (!m_busy) begin
        e = c; m_alpha = a;
        exp_t.push_back(l ? "R6 single term" : "R1 leading term");
      end else begin
        e = model(m_alpha, m_prev, c, cl);
        exp_t.push_back(cl ? "R3 saturation" : "R2 chained term");
      end
      m_prev = e; m_busy = !l;
      exp_d.push_back(e); exp_l.push_back(l);
    end
  endtask

  task automatic send(logic [DW-1:0] c, bit l, logic [DW-1:0] a, int rdy_pct);
    accepted = 0;
    while (!accepted) cycle(($urandom % 100) < rdy_pct, 1'b1, c, l, a);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", out_valid, 0);
    check("R8 reset coef_ready", coef_ready, 1);
    rst_n = 1'b1;

    // R1/R2: x^2 - 3x + 2 at alpha=2 -> quotient 1,-1 remainder 0
    send(16'h0100, 0, 16'h0200, 100);
    send(16'hFD00, 0, 16'h0000, 100);
    send(16'h0200, 1, 16'h0000, 100);
    drain();

    // R4: alpha changes on every non-leading beat
    send(16'h0180, 0, 16'h0140, 100);
    for (int i = 0; i < 4; i++) send(16'($urandom), i == 3, 16'($urandom), 100);
    drain();

    // R6: degree zero twice back to back
    send(16'h8123, 1, 16'h7777, 100);
    send(16'h1234, 1, 16'h0300, 100);
    drain();

    // R3: overflow both directions
    send(16'h7000, 0, 16'h7F00, 100);
    send(16'h7000, 1, 16'h0000, 100);
    send(16'h7000, 0, 16'h8100, 100);
    send(16'h7000, 1, 16'h0000, 100);
    drain();

    // R7: stall holds output and blocks input
    send(16'h0a0a, 0, 16'h0100, 100);
    #0;
    cycle(1'b0, 1'b1, 16'h0505, 1'b1, 16'h0000);
    held = out_data;
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 1'b1, 16'h0505, 1'b1, 16'h0000);
      check("R7 coef_ready low in stall", coef_ready, 0);
      check("R7 out_data held", out_data, held);
    end
    send(16'h0505, 1, 16'h0000, 100);
    drain();

    // R8: reset in the middle of a polynomial
    send(16'h0300, 0, 16'h0200, 100);
    send(16'h0100, 0, 16'h0200, 100);
    @(negedge clk); rst_n = 1'b0; coef_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_d.delete(); exp_l.delete(); exp_t.delete(); m_busy = 0;
    send(16'h4242, 0, 16'h0100, 100);
    @(negedge clk); out_ready = 1'b0; coef_valid = 1'b0; #1;
    check("R8 first after reset passes through", out_data, 16'h4242);
    send(16'h0001, 1, 16'h0000, 100);
    drain();

    // random polynomials with random gaps and backpressure
    for (int p = 0; p < 300; p++) begin
      int deg = $urandom % 7;
      logic [DW-1:0] a = (p % 5 == 0) ? 16'($urandom) : 16'($signed($urandom % 1025) - 512);
      for (int k = 0; k <= deg; k++) begin
        if ($urandom % 4 == 0) cycle($urandom % 2, 1'b0, '0, 1'b0, '0);
        send(16'($urandom), k == deg, (k == 0) ? a : 16'($urandom), 70);
      end
    end
    drain();
    check("R7 no output lost", exp_d.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule